// File: doc/BRIEF.md
# Frame Delta Bounding-Box Encoder

This block takes a stream of pixels for each new frame of a small fixed-size image and compares every pixel with the pixel at the same position in the frame before it. The previous frame is kept in an internal frame store. As the comparison runs, the block tracks the smallest rectangle that contains every changed pixel. At the end of the frame it reports that rectangle as an origin and a size. It then streams out only the pixels inside the rectangle, in raster order.

A receiver keeps its own copy of the last frame. It overwrites the rectangle with the patch pixels and leaves everything outside the rectangle as it was. Pixels are palette indices. The default frame is 64 by 64, and the frame store is addressed by row and then column. Input is refused while a descriptor or patch is still pending, so the stored frame cannot be overwritten before its patch has been read out.

Top module: `fbox_enc`

## Requirements
- R1: While reset is held and right after it is released, `in_ready` is 1 and both `desc_valid` and `out_valid` are 0.
- R2: The first frame after reset is reported as fully changed. Its descriptor is x=0, y=0, w=W, h=H (W=2^XW, H=2^YW), and its patch holds all W*H pixels.
- R3: A frame starts with the pixel that carries `in_sof`. The k-th pixel of the frame (counting from 0) sits at x = k mod W and y = k div W. If exactly one pixel at (x,y) differs from the previous frame, the descriptor is x, y, 1, 1.
- R4: When several pixels differ, the descriptor is the smallest enclosing box. Its origin is the lowest changed column and the lowest changed row. Its width is the highest changed column minus the lowest, plus 1, and its height is the highest changed row minus the lowest, plus 1.
- R5: If no pixel differs, the descriptor is 0, 0, 0, 0. No patch pixel follows, and input is accepted again once the descriptor has been taken.
- R6: After the descriptor handshake, exactly w*h patch pixels are emitted. Rows run from top to bottom, and within each row pixels run from left to right. Each value equals the new frame's pixel at that position.
- R7: A pixel that is offered while no frame is in progress and that lacks `in_sof` is consumed and discarded. It does not start a frame and does not change the stored frame.
- R8: `in_ready` is 0 while the descriptor or the patch is pending. It returns to 1 once the last patch pixel has been taken.
- R9: While `desc_ready` is 0, a valid descriptor holds its fields. While `out_ready` is 0, a valid patch pixel holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PW | Input pixel value |
| desc_valid | output | 1 | Rectangle descriptor valid |
| desc_ready | input | 1 | Descriptor accepted by consumer |
| desc_x | output | XW | Rectangle left column |
| desc_y | output | YW | Rectangle top row |
| desc_w | output | XW+1 | Rectangle width, 0 if nothing changed |
| desc_h | output | YW+1 | Rectangle height, 0 if nothing changed |
| out_valid | output | 1 | Patch pixel valid |
| out_ready | input | 1 | Patch pixel accepted by consumer |
| out_pix | output | PW | Patch pixel value |

## Verification
The bench uses an 8 by 8 configuration. It first sends a fresh frame after reset, which tells the forced full box apart from a real comparison. It then repeats an identical frame, which must give the empty descriptor with no patch. Next it sends stray pixels without a start marker followed by a repeated frame; an empty result there shows that the stray pixels neither opened a frame nor reached the store. It then changes a single pixel at each of the 64 positions in turn, which separates column from row and checks the edges of the box. It also runs pairs of changes spread over the image and one frame in which every pixel changes; these exercise the minimum and maximum tracking on both axes and the raster order of the patch. Throughout, the patch port is throttled in a pseudo-random pattern and the descriptor is stalled once per frame, so that the hold behaviour is checked as well.

// File: rtl/fbox_pkg.sv
// Shared types for the frame delta bounding-box encoder.
package fbox_pkg;

    // Controller phases: waiting for a frame start, loading pixels,
    // finishing the last comparison, offering the descriptor, and the
    // two-step read/show loop that drains the patch.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_FIN  = 3'd2,
        ST_DESC = 3'd3,
        ST_RD   = 3'd4,
        ST_SHOW = 3'd5
    } fbox_state_e;

endpackage

// File: rtl/fbox_store.sv
// Frame store: one write port and one read port, both synchronous.
// Assumes read-first behaviour when both ports hit the same address in
// one cycle; the controller relies on this to fetch the old pixel while
// it writes the new one.
module fbox_store #(
    parameter int AW = 12,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [PW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] mem [DEPTH];

    // Write the new pixel and register the old contents on request.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/fbox_span.sv
// One-axis span tracker: keeps the lowest and highest coordinate seen
// since the last clear. Assumes clear and update never coincide.
module fbox_span #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [CW-1:0] val,
    output logic [CW-1:0] lo,
    output logic [CW-1:0] hi,
    output logic          seen
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // Reset to an empty span, then widen it on every update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo   <= TOP;
            hi   <= '0;
            seen <= 1'b0;
        end else if (upd) begin
            if (val < lo) lo <= val;
            if (val > hi) hi <= val;
            seen <= 1'b1;
        end
    end

    AST_SPAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (lo <= hi)); // R4

endmodule

// File: rtl/fbox_ctrl.sv
// Encoder controller. It accepts a frame, compares each pixel with the
// stored one a cycle later, feeds mismatch coordinates to the span
// trackers, offers the descriptor, and then walks the box in raster
// order, reading the frame store. Assumes a frame has exactly 2^(XW+YW)
// pixels and that its first pixel carries the start marker.
module fbox_ctrl
    import fbox_pkg::*;
#(
    parameter int XW = 6,
    parameter int YW = 6,
    parameter int PW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PW-1:0]    in_pix,
    output logic             in_ready,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic [XW-1:0]    desc_x,
    output logic [YW-1:0]    desc_y,
    output logic [XW:0]      desc_w,
    output logic [YW:0]      desc_h,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PW-1:0]    out_pix,
    output logic             st_we,
    output logic [XW+YW-1:0] st_waddr,
    output logic [PW-1:0]    st_wdata,
    output logic             st_re,
    output logic [XW+YW-1:0] st_raddr,
    input  logic [PW-1:0]    st_rdata,
    output logic             sp_clr,
    output logic             sp_upd,
    output logic [XW-1:0]    sp_x,
    output logic [YW-1:0]    sp_y,
    input  logic [XW-1:0]    sp_xlo,
    input  logic [XW-1:0]    sp_xhi,
    input  logic [YW-1:0]    sp_ylo,
    input  logic [YW-1:0]    sp_yhi,
    input  logic             sp_seen
);
    localparam int AW = XW + YW;
    localparam logic [AW-1:0] LAST_POS = {AW{1'b1}};
    localparam logic [XW-1:0] XMAX = {XW{1'b1}};
    localparam logic [YW-1:0] YMAX = {YW{1'b1}};

    fbox_state_e   state;
    logic [AW-1:0] cnt;
    logic          primed;
    logic          cmp_vld;
    logic [PW-1:0] cmp_pix;
    logic [XW-1:0] cmp_x;
    logic [YW-1:0] cmp_y;
    logic [XW-1:0] ox, hx0, hx1;
    logic [YW-1:0] oy, hy0, hy1;

    logic          acc, take;
    logic [AW-1:0] pos;
    logic          nz;
    logic [XW-1:0] bx0, bx1;
    logic [YW-1:0] by0, by1;

    // Input acceptance and frame store addressing.
    always_comb begin
        in_ready = (state == ST_IDLE) || (state == ST_LOAD);
        acc      = in_valid && in_ready;
        take     = acc && ((state == ST_LOAD) || in_sof);
        pos      = (state == ST_IDLE) ? '0 : cnt;
        st_we    = take;
        st_waddr = pos;
        st_wdata = in_pix;
        st_re    = take || (state == ST_RD);
        st_raddr = (state == ST_RD) ? {oy, ox} : pos;
    end

    // Mismatch detection one cycle after the pixel entered.
    always_comb begin
        sp_clr = acc && (state == ST_IDLE) && in_sof;
        sp_upd = cmp_vld && primed && (cmp_pix != st_rdata);
        sp_x   = cmp_x;
        sp_y   = cmp_y;
    end

    // Box selection: full frame before the first store, span otherwise.
    always_comb begin
        if (!primed) begin
            nz = 1'b1; bx0 = '0; bx1 = XMAX; by0 = '0; by1 = YMAX;
        end else if (sp_seen) begin
            nz = 1'b1; bx0 = sp_xlo; bx1 = sp_xhi; by0 = sp_ylo; by1 = sp_yhi;
        end else begin
            nz = 1'b0; bx0 = '0; bx1 = '0; by0 = '0; by1 = '0;
        end
    end

    // Descriptor and patch outputs.
    always_comb begin
        desc_valid = (state == ST_DESC);
        desc_x     = bx0;
        desc_y     = by0;
        desc_w     = nz ? ({1'b0, bx1} - {1'b0, bx0} + {{XW{1'b0}}, 1'b1}) : '0;
        desc_h     = nz ? ({1'b0, by1} - {1'b0, by0} + {{YW{1'b0}}, 1'b1}) : '0;
        out_valid  = (state == ST_SHOW);
        out_pix    = st_rdata;
    end

    // Comparison stage register: remembers the pixel just written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_vld <= 1'b0;
            cmp_pix <= '0;
            cmp_x   <= '0;
            cmp_y   <= '0;
        end else begin
            cmp_vld <= take;
            if (take) begin
                cmp_pix <= in_pix;
                cmp_x   <= pos[XW-1:0];
                cmp_y   <= pos[AW-1:XW];
            end
        end
    end

    // Phase sequencing, pixel counter and patch walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            primed <= 1'b0;
            ox     <= '0;
            oy     <= '0;
            hx0    <= '0;
            hx1    <= '0;
            hy0    <= '0;
            hy1    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    cnt   <= {{(AW-1){1'b0}}, 1'b1};
                    state <= ST_LOAD;
                end
                ST_LOAD: if (take) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_POS) state <= ST_FIN;
                end
                ST_FIN: state <= ST_DESC;
                ST_DESC: if (desc_ready) begin
                    primed <= 1'b1;
                    hx0    <= bx0;
                    hx1    <= bx1;
                    hy0    <= by0;
                    hy1    <= by1;
                    ox     <= bx0;
                    oy     <= by0;
                    state  <= nz ? ST_RD : ST_IDLE;
                end
                ST_RD: state <= ST_SHOW;
                ST_SHOW: if (out_ready) begin
                    if (ox == hx1 && oy == hy1) begin
                        state <= ST_IDLE;
                    end else begin
                        if (ox == hx1) begin
                            ox <= hx0;
                            oy <= oy + 1'b1;
                        end else begin
                            ox <= ox + 1'b1;
                        end
                        state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_x) && $stable(desc_y)
            && $stable(desc_w) && $stable(desc_h)); // R9
    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R9
    AST_NO_INPUT_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid || out_valid) |-> !in_ready); // R8
    AST_EMPTY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ((desc_w == '0) == (desc_h == '0))); // R5
    AST_WALK_IN_BOX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ox >= hx0 && ox <= hx1 && oy >= hy0 && oy <= hy1)); // R6

endmodule

// File: rtl/fbox_enc.sv
// Frame delta bounding-box encoder top. It wires the frame store, one
// span tracker per axis and the controller. Assumes frames of
// 2^XW by 2^YW pixels, each led by a start-marked pixel.
module fbox_enc #(
    parameter int XW = 6,
    parameter int YW = 6,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sof,
    input  logic [PW-1:0] in_pix,
    output logic          desc_valid,
    input  logic          desc_ready,
    output logic [XW-1:0] desc_x,
    output logic [YW-1:0] desc_y,
    output logic [XW:0]   desc_w,
    output logic [YW:0]   desc_h,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_pix
);
    localparam int AW = XW + YW;

    logic          st_we, st_re;
    logic [AW-1:0] st_waddr, st_raddr;
    logic [PW-1:0] st_wdata, st_rdata;
    logic          sp_clr, sp_upd, seen_x, seen_y;
    logic [XW-1:0] sp_x, xlo, xhi;
    logic [YW-1:0] sp_y, ylo, yhi;

    fbox_store #(.AW(AW), .PW(PW)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .re(st_re), .raddr(st_raddr), .rdata(st_rdata)
    );

    fbox_span #(.CW(XW)) u_span_x (
        .clk(clk), .rst_n(rst_n), .clr(sp_clr), .upd(sp_upd), .val(sp_x),
        .lo(xlo), .hi(xhi), .seen(seen_x)
    );

    fbox_span #(.CW(YW)) u_span_y (
        .clk(clk), .rst_n(rst_n), .clr(sp_clr), .upd(sp_upd), .val(sp_y),
        .lo(ylo), .hi(yhi), .seen(seen_y)
    );

    fbox_ctrl #(.XW(XW), .YW(YW), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix), .in_ready(in_ready),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_x(desc_x), .desc_y(desc_y), .desc_w(desc_w), .desc_h(desc_h),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata),
        .st_re(st_re), .st_raddr(st_raddr), .st_rdata(st_rdata),
        .sp_clr(sp_clr), .sp_upd(sp_upd), .sp_x(sp_x), .sp_y(sp_y),
        .sp_xlo(xlo), .sp_xhi(xhi), .sp_ylo(ylo), .sp_yhi(yhi),
        .sp_seen(seen_x)
    );

    // Both trackers see the same update strobe, so their flags must agree.
    AST_SPAN_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_x == seen_y); // R4

endmodule

// File: tb/fbox_enc_bench.sv
// Self-checking bench for fbox_enc on an 8x8 frame with 4-bit pixels.
module fbox_enc_bench;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int PW = 4;
    localparam int W  = 1 << XW;
    localparam int H  = 1 << YW;
    localparam int N  = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, desc_ready = 1'b0, out_ready = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic in_ready, desc_valid, out_valid;
    logic [XW-1:0] desc_x;
    logic [YW-1:0] desc_y;
    logic [XW:0]   desc_w;
    logic [YW:0]   desc_h;
    logic [PW-1:0] out_pix;

    always #10 clk = ~clk;

    fbox_enc #(.XW(XW), .YW(YW), .PW(PW)) u_fbox_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_x(desc_x), .desc_y(desc_y), .desc_w(desc_w), .desc_h(desc_h),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    logic [PW-1:0] prev [N];
    logic [PW-1:0] cur  [N];
    bit have_prev = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            miscompares++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    // Offer one pixel from a falling edge and return at the falling edge
    // after the rising edge on which it was taken.
    task automatic push(input logic [PW-1:0] p, input logic s);
        in_valid = 1'b1;
        in_pix   = p;
        in_sof   = s;
        forever begin
            automatic logic r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic run_frame(input string req);
        int ex0, ey0, ex1, ey1, ew, eh;
        logic [XW-1:0] sx;
        logic [YW-1:0] sy;
        logic [XW:0]   sw;
        logic [YW:0]   sh;
        if (!have_prev) begin
            ex0 = 0; ey0 = 0; ex1 = W - 1; ey1 = H - 1;
        end else begin
            ex0 = W; ey0 = H; ex1 = -1; ey1 = -1;
            for (int k = 0; k < N; k++) begin
                if (cur[k] != prev[k]) begin
                    if (k % W < ex0) ex0 = k % W;
                    if (k % W > ex1) ex1 = k % W;
                    if (k / W < ey0) ey0 = k / W;
                    if (k / W > ey1) ey1 = k / W;
                end
            end
        end
        if (ex1 < 0) begin
            ex0 = 0; ey0 = 0; ew = 0; eh = 0;
        end else begin
            ew = ex1 - ex0 + 1; eh = ey1 - ey0 + 1;
        end

        for (int k = 0; k < N; k++) push(cur[k], k == 0);

        while (!desc_valid) @(negedge clk);
        chk("R8 in_ready during descriptor", int'(in_ready), 0);
        chk({req, " desc x"}, int'(desc_x), ex0);
        chk({req, " desc y"}, int'(desc_y), ey0);
        chk({req, " desc w"}, int'(desc_w), ew);
        chk({req, " desc h"}, int'(desc_h), eh);
        sx = desc_x; sy = desc_y; sw = desc_w; sh = desc_h;
        @(negedge clk);
        chk("R9 descriptor held", int'(desc_valid && desc_x == sx && desc_y == sy
            && desc_w == sw && desc_h == sh), 1);
        desc_ready = 1'b1;
        @(negedge clk);
        desc_ready = 1'b0;

        if (ew == 0) begin
            chk("R5 no patch after empty box", int'(out_valid), 0);
            chk("R5 input reopened", int'(in_ready), 1);
        end else begin
            for (int y = ey0; y < ey0 + eh; y++) begin
                for (int x = ex0; x < ex0 + ew; x++) begin
                    logic [PW-1:0] got;
                    forever begin
                        automatic logic r;
                        automatic logic v;
                        automatic logic [PW-1:0] p;
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        out_ready = lfsr[0] | lfsr[3];
                        r = out_ready; v = out_valid; p = out_pix;
                        @(negedge clk);
                        if (v && r) begin
                            got = p;
                            break;
                        end
                        if (v) chk("R9 patch pixel held", int'(out_valid && out_pix == p), 1);
                    end
                    chk("R6 patch pixel", int'(got), int'(cur[y * W + x]));
                end
            end
            out_ready = 1'b0;
            chk("R6 no extra patch pixel", int'(out_valid), 0);
            chk("R8 input reopened after patch", int'(in_ready), 1);
        end
        prev = cur;
        have_prev = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset in_ready", int'(in_ready), 1);
        chk("R1 reset desc_valid", int'(desc_valid), 0);
        chk("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset out_valid", int'(out_valid), 0);

        // First frame after reset: forced full box.
        for (int k = 0; k < N; k++) cur[k] = PW'((k * 7 + 3) % 16);
        run_frame("R2");

        // Identical frame: empty descriptor.
        run_frame("R5");

        // Stray pixels without a start marker, then an identical frame.
        for (int k = 0; k < 5; k++) push(PW'(k + 9), 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 stray pixels open no frame", int'(desc_valid), 0);
        run_frame("R7");

        // Single changed pixel at every position.
        for (int i = 0; i < N; i++) begin
            cur = prev;
            cur[i] = prev[i] ^ PW'((i % 15) + 1);
            run_frame("R3");
        end

        // Two changed pixels spread over the image.
        for (int i = 0; i < N; i++) begin
            automatic int j = (i * 37 + 11) % N;
            cur = prev;
            cur[i] = cur[i] ^ PW'((i % 15) + 1);
            cur[j] = cur[j] ^ 4'h5;
            run_frame("R4");
        end

        // Every pixel changes.
        cur = prev;
        for (int k = 0; k < N; k++) cur[k] = prev[k] ^ 4'h1;
        run_frame("R4 full");

        finish_run();
    end

endmodule